// File: doc/BRIEF.md
# TDM Codec Serial Port with Control Slots

This block is a clock-master serial port that talks to an audio codec over a four-wire time-division link. It divides the system clock to make the serial bit clock, marks each frame with a one-bit-wide sync pulse, and cuts every frame into eight 16-bit slots. Each slot is shifted MSB first. Four logical channels share the frame: a left and a right audio word, and two control channels. The control channels send commands to the codec and bring back its status words.

Each direction of each channel has its own slot number and its own enable, so software can choose the order of the channels within the frame. The audio channels have separate transmit and receive slot numbers. A control channel uses one slot number and one enable for both directions. Transmit words are written into holding registers through a write strobe. Received words come out through a valid/ready port that names the channel that owns each word.

Transmit and receive run at the same time. Receive data is sampled on the bit-clock edge chosen by a single edge-select input.

Top module: `tdm_codec_port`

## Requirements
- R1: The bit clock `sck` has a period of 2*`cfg_half` system clocks, where a `cfg_half` of 0 counts as 1. It is low after reset, and its first edge is a rising edge.
- R2: A frame is 128 bit clocks long. `fsync` is high for exactly one bit-clock period: the bit just before the first bit of slot 0, which is frame bit 127. `fsync` and `txd` change only when `sck` falls.
- R3: Slot n covers frame bits 16n to 16n+15. In that slot `txd` carries the word of the enabled transmit channel whose slot field equals n, most significant bit first.
- R4: When several enabled transmit channels name the same slot, the one with the lowest channel code sends. The channel codes are 0 for left, 1 for right, 2 for control 0 and 3 for control 1.
- R5: `txd` is 0 during any slot that no enabled transmit channel claims. A slot field of 8 or more never matches any slot.
- R6: A write with `tx_we` stores `tx_wdata` for the channel coded by `tx_sel`, using the R4 codes. A frame sends the words that are held as it begins. A write made during a frame first shows in the next frame.
- R7: Receive sampling uses the rising edge of `sck` when `rx_edge`=0 and the falling edge when `rx_edge`=1. At the end of slot n, the 16-bit word is given to every enabled receive channel whose slot field equals n. A slot field of 8 or more never matches. Control channels receive in their transmit slot.
- R8: `rx_valid` is high while any channel holds an unread word. `rx_chan` and `rx_data` present the pending word with the lowest channel code. That word is removed when `rx_valid` and `rx_ready` are both high at a clock edge, and `rx_valid` stays high until then.
- R9: Bit c of `rx_overrun` (c being the channel code) is set when a new word reaches channel c while its previous word is still unread. Once set, the bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_half | input | DIV_W | Half of the bit-clock period in system clocks |
| rx_edge | input | 1 | Receive sampling edge: 0 rising, 1 falling |
| slot_tx_l | input | SEL_W | Slot number of left transmit |
| slot_tx_r | input | SEL_W | Slot number of right transmit |
| slot_rx_l | input | SEL_W | Slot number of left receive |
| slot_rx_r | input | SEL_W | Slot number of right receive |
| slot_ctl0 | input | SEL_W | Slot number of control channel 0, both directions |
| slot_ctl1 | input | SEL_W | Slot number of control channel 1, both directions |
| en_tx_l | input | 1 | Left transmit enable |
| en_tx_r | input | 1 | Right transmit enable |
| en_rx_l | input | 1 | Left receive enable |
| en_rx_r | input | 1 | Right receive enable |
| en_ctl0 | input | 1 | Control channel 0 enable |
| en_ctl1 | input | 1 | Control channel 1 enable |
| tx_we | input | 1 | Transmit holding register write strobe |
| tx_sel | input | 2 | Channel code of the write |
| tx_wdata | input | WORD_W | Word to transmit |
| rx_data | output | WORD_W | Received word of the channel presented |
| rx_chan | output | 2 | Channel code of the word presented |
| rx_valid | output | 1 | A received word is pending |
| rx_ready | input | 1 | Consumer takes the word presented |
| rx_overrun | output | 4 | Sticky per-channel overrun flags |
| sck | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync pulse |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
Each transmit bit appears at a falling edge of `sck`. The bench codec model captures it at the next rising edge and therefore never reads a bit on the edge where it changes. Configuration and word changes land at arbitrary points in a frame, so the bench sends and checks nothing before two frame ends have passed, and then compares the third whole frame. It takes received words as they are popped, which is one clock after the sampling edge of the last bit of a slot. It checks them eight system clocks after the frame ends, which leaves room for the slot-7 word under either sampling edge. The frame-boundary test for write timing compares the frame that was running during the write with the frame after it.

// File: rtl/tdm_codec_port.sv
module tdm_codec_port #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 16,
  parameter int SLOTS  = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              rx_edge,
  input  logic [SEL_W-1:0]  slot_tx_l,
  input  logic [SEL_W-1:0]  slot_tx_r,
  input  logic [SEL_W-1:0]  slot_rx_l,
  input  logic [SEL_W-1:0]  slot_rx_r,
  input  logic [SEL_W-1:0]  slot_ctl0,
  input  logic [SEL_W-1:0]  slot_ctl1,
  input  logic              en_tx_l,
  input  logic              en_tx_r,
  input  logic              en_rx_l,
  input  logic              en_rx_r,
  input  logic              en_ctl0,
  input  logic              en_ctl1,
  input  logic              tx_we,
  input  logic [1:0]        tx_sel,
  input  logic [WORD_W-1:0] tx_wdata,
  output logic [WORD_W-1:0] rx_data,
  output logic [1:0]        rx_chan,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [3:0]        rx_overrun,
  output logic              sck,
  output logic              fsync,
  output logic              txd,
  input  logic              rxd
);
  localparam int NCH        = 4;
  localparam int FRAME_BITS = SLOTS * WORD_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int POS_W      = $clog2(WORD_W);
  localparam int LAST       = FRAME_BITS - 1;

  // bit clock
  logic [DIV_W-1:0] cnt, lim;
  logic sck_q, tick, rise, fall;

  assign lim  = (cfg_half == '0) ? '0 : cfg_half - 1'b1;
  assign tick = (cnt >= lim);
  assign rise = tick & ~sck_q;
  assign fall = tick & sck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt <= cnt + 1'b1;
    end

  // frame position
  logic [BIT_W-1:0] bitc, nb;
  logic [POS_W-1:0] npos;
  assign nb   = (bitc == BIT_W'(LAST)) ? '0 : bitc + 1'b1;
  assign npos = nb[POS_W-1:0];

  // channel tables
  logic [SEL_W-1:0]  tslot [NCH];
  logic [SEL_W-1:0]  rslot [NCH];
  logic [NCH-1:0]    ten, ren;
  assign tslot[0] = slot_tx_l;
  assign tslot[1] = slot_tx_r;
  assign tslot[2] = slot_ctl0;
  assign tslot[3] = slot_ctl1;
  assign rslot[0] = slot_rx_l;
  assign rslot[1] = slot_rx_r;
  assign rslot[2] = slot_ctl0;
  assign rslot[3] = slot_ctl1;
  assign ten = {en_ctl1, en_ctl0, en_tx_r, en_tx_l};
  assign ren = {en_ctl1, en_ctl0, en_rx_r, en_rx_l};

  // transmit
  logic [WORD_W-1:0] hold [NCH];
  logic [WORD_W-1:0] shad [NCH];
  logic [WORD_W-1:0] tx_word;
  logic tx_hit, tx_bit, fs_q, txd_q;

  always_comb begin
    tx_hit  = 1'b0;
    tx_word = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (ten[c] && tslot[c] == SEL_W'(nb[BIT_W-1:POS_W])) begin
        tx_hit  = 1'b1;
        tx_word = (nb == '0) ? hold[c] : shad[c];
      end
  end
  assign tx_bit = tx_hit & tx_word[POS_W'(WORD_W - 1) - npos];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int c = 0; c < NCH; c++) hold[c] <= '0;
    else if (tx_we)
      hold[tx_sel] <= tx_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitc  <= BIT_W'(LAST - 1);
      fs_q  <= 1'b0;
      txd_q <= 1'b0;
      for (int c = 0; c < NCH; c++) shad[c] <= '0;
    end else if (fall) begin
      bitc  <= nb;
      fs_q  <= (nb == BIT_W'(LAST));
      txd_q <= tx_bit;
      if (nb == '0)
        for (int c = 0; c < NCH; c++) shad[c] <= hold[c];
    end

  // receive
  logic              smp, last_bit;
  logic [WORD_W-2:0] rsh;
  logic [WORD_W-1:0] rword;
  logic [NCH-1:0]    deliver, rxv, ovr;
  logic [WORD_W-1:0] rxh [NCH];
  logic [1:0]        out_ch;
  logic              pop;

  assign smp      = rx_edge ? fall : rise;
  assign last_bit = (bitc[POS_W-1:0] == {POS_W{1'b1}});
  assign rword    = {rsh, rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   rsh <= '0;
    else if (smp) rsh <= rword[WORD_W-2:0];

  for (genvar g = 0; g < NCH; g++) begin : g_match
    assign deliver[g] = smp & last_bit & ren[g] &
                        (rslot[g] == SEL_W'(bitc[BIT_W-1:POS_W]));
  end

  always_comb begin
    out_ch = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (rxv[c]) out_ch = 2'(c);
  end
  assign rx_valid = |rxv;
  assign pop      = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxv <= '0;
      ovr <= '0;
      for (int c = 0; c < NCH; c++) rxh[c] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (deliver[c]) begin
          rxh[c] <= rword;
          rxv[c] <= 1'b1;
          if (rxv[c] && !(pop && out_ch == 2'(c))) ovr[c] <= 1'b1;
        end else if (pop && out_ch == 2'(c)) begin
          rxv[c] <= 1'b0;
        end
    end

  assign rx_data    = rxh[out_ch];
  assign rx_chan    = out_ch;
  assign rx_overrun = ovr;
  assign sck        = sck_q;
  assign fsync      = fs_q;
  assign txd        = txd_q;
endmodule

// File: rtl/tdm_codec_port_chk.sv
module tdm_codec_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       fsync,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [3:0] rx_overrun
);
  // R2
  fsync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $fell(sck));

  // R2
  txd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $fell(sck));

  // R2
  fsync_low_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> !sck);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rx_overrun & $past(rx_overrun)) == $past(rx_overrun)));
endmodule

bind tdm_codec_port tdm_codec_port_chk u_chk (.*);

// File: tb/tdm_codec_port_tb.sv
module tdm_codec_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd2;
  logic        rx_edge = 1'b0;
  logic [3:0]  slot_tx_l = '0, slot_tx_r = '0, slot_rx_l = '0, slot_rx_r = '0;
  logic [3:0]  slot_ctl0 = '0, slot_ctl1 = '0;
  logic        en_tx_l = 0, en_tx_r = 0, en_rx_l = 0, en_rx_r = 0, en_ctl0 = 0, en_ctl1 = 0;
  logic        tx_we = 1'b0;
  logic [1:0]  tx_sel = '0;
  logic [15:0] tx_wdata = '0;
  logic [15:0] rx_data;
  logic [1:0]  rx_chan;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [3:0]  rx_overrun;
  logic        sck, fsync, txd;
  logic        rxd = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdm_codec_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .rx_edge(rx_edge),
    .slot_tx_l(slot_tx_l), .slot_tx_r(slot_tx_r), .slot_rx_l(slot_rx_l),
    .slot_rx_r(slot_rx_r), .slot_ctl0(slot_ctl0), .slot_ctl1(slot_ctl1),
    .en_tx_l(en_tx_l), .en_tx_r(en_tx_r), .en_rx_l(en_rx_l), .en_rx_r(en_rx_r),
    .en_ctl0(en_ctl0), .en_ctl1(en_ctl1), .tx_we(tx_we), .tx_sel(tx_sel),
    .tx_wdata(tx_wdata), .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun), .sck(sck), .fsync(fsync),
    .txd(txd), .rxd(rxd));

  int checks = 0, fails = 0;
  bit done = 0;

  int unsigned tslot_b [4], rslot_b [4];
  bit          ten_b [4], ren_b [4];
  logic [15:0] txw_b [4];
  logic [15:0] rxpat [8];
  bit          edge_b = 0;

  // codec model
  int bitn = 0, frames = 0, fs_err = 0;
  bit synced = 0, fs_pend = 0;
  logic [15:0] cap [8], last_frame [8];

  initial forever begin
    @(posedge sck); #1;
    if (synced) begin
      cap[bitn / 16][15 - bitn % 16] = txd;
      if (fsync != (bitn == 127)) fs_err++;
      if (bitn == 127) begin
        last_frame = cap;
        frames++;
      end
      if (edge_b) rxd = rxpat[bitn / 16][15 - bitn % 16];
    end
    fs_pend = fsync;
  end

  initial forever begin
    @(negedge sck); #1;
    if (fs_pend) begin
      bitn = 0;
      synced = 1;
    end else if (synced) begin
      bitn = (bitn + 1) % 128;
    end
    if (synced && !edge_b) rxd = rxpat[bitn / 16][15 - bitn % 16];
  end

  // receive drain
  logic [15:0] got [4];
  bit          gotf [4];
  int          ord [8];
  int          n_ord = 0;

  initial forever begin
    @(negedge clk);
    if (rx_valid && rx_ready) begin
      got[rx_chan]  = rx_data;
      gotf[rx_chan] = 1;
      if (n_ord < 8) begin
        ord[n_ord] = int'(rx_chan);
        n_ord++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg();
    @(posedge clk); #1;
    rx_edge   = edge_b;
    slot_tx_l = tslot_b[0][3:0]; en_tx_l = ten_b[0];
    slot_tx_r = tslot_b[1][3:0]; en_tx_r = ten_b[1];
    slot_ctl0 = tslot_b[2][3:0]; en_ctl0 = ten_b[2];
    slot_ctl1 = tslot_b[3][3:0]; en_ctl1 = ten_b[3];
    slot_rx_l = rslot_b[0][3:0]; en_rx_l = ren_b[0];
    slot_rx_r = rslot_b[1][3:0]; en_rx_r = ren_b[1];
  endtask

  task automatic write_tx(input int c, input logic [15:0] w);
    @(posedge clk); #1;
    tx_we = 1; tx_sel = 2'(c); tx_wdata = w;
    @(posedge clk); #1;
    tx_we = 0;
  endtask

  task automatic wait_frames(input int n);
    int target = frames + n;
    while (frames < target) @(posedge clk);
  endtask

  function automatic logic [15:0] exp_tx(input int s);
    logic [15:0] r = '0;
    for (int c = 3; c >= 0; c--)
      if (ten_b[c] && tslot_b[c] == s) r = txw_b[c];
    return r;
  endfunction

  function automatic int owners(input int s);
    int n = 0;
    for (int c = 0; c < 4; c++)
      if (ten_b[c] && tslot_b[c] == s) n++;
    return n;
  endfunction

  task automatic run_frame_case(input string name);
    for (int s = 0; s < 8; s++) rxpat[s] = 16'($urandom);
    rslot_b[2] = tslot_b[2]; ren_b[2] = ten_b[2];
    rslot_b[3] = tslot_b[3]; ren_b[3] = ten_b[3];
    apply_cfg();
    for (int c = 0; c < 4; c++) begin
      txw_b[c] = 16'($urandom);
      write_tx(c, txw_b[c]);
    end
    wait_frames(2);
    repeat (8) @(posedge clk);
    for (int c = 0; c < 4; c++) gotf[c] = 0;
    wait_frames(1);
    repeat (8) @(posedge clk);
    for (int s = 0; s < 8; s++) begin
      int n = owners(s);
      if (n > 1)
        chk(last_frame[s] == exp_tx(s), "R4", {name, " tx slot priority"}, 32'(last_frame[s]), 32'(exp_tx(s)));
      else if (n == 0)
        chk(last_frame[s] == 16'h0, "R5", {name, " tx idle slot"}, 32'(last_frame[s]), 32'h0);
      else
        chk(last_frame[s] == exp_tx(s), "R3", {name, " tx slot word"}, 32'(last_frame[s]), 32'(exp_tx(s)));
    end
    for (int c = 0; c < 4; c++) begin
      if (ren_b[c] && rslot_b[c] < 8)
        chk(gotf[c] && got[c] == rxpat[rslot_b[c]], "R7", {name, " rx word"},
            32'(got[c]), 32'(rxpat[rslot_b[c]]));
      else
        chk(!gotf[c], "R7", {name, " rx channel must stay silent"}, 32'(gotf[c]), 32'h0);
    end
    chk(rx_overrun == 4'h0, "R9", {name, " no overrun while drained"}, 32'(rx_overrun), 32'h0);
  endtask

  task automatic set_ch(input int c, input int ts, input bit te, input int rs, input bit re);
    tslot_b[c] = ts; ten_b[c] = te; rslot_b[c] = rs; ren_b[c] = re;
  endtask

  task automatic meas(input int half, input int exp_clks);
    time t0;
    @(posedge clk); #1;
    cfg_half = 8'(half);
    repeat (3) @(posedge sck);
    t0 = $time;
    @(posedge sck);
    chk(($time - t0) == exp_clks * CLK_PERIOD, "R1", "sck period in clocks",
        32'(($time - t0) / CLK_PERIOD), 32'(exp_clks));
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 8; s++) rxpat[s] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sck == 1'b0, "R1", "sck low in reset", 32'(sck), 32'h0);
    chk(fsync == 1'b0 && txd == 1'b0, "R2", "fsync and txd low in reset", 32'({fsync, txd}), 32'h0);
    chk(rx_valid == 1'b0, "R8", "no word in reset", 32'(rx_valid), 32'h0);
    chk(rx_overrun == 4'h0, "R9", "overrun clear in reset", 32'(rx_overrun), 32'h0);
    rst_n = 1'b1;

    meas(2, 4);
    meas(1, 2);
    meas(0, 2);
    meas(3, 6);
    meas(5, 10);
    @(posedge clk); #1;
    cfg_half = 8'd2;

    // example layout
    edge_b = 0;
    set_ch(0, 0, 1, 0, 1);
    set_ch(1, 2, 1, 2, 1);
    set_ch(2, 1, 1, 1, 1);
    set_ch(3, 3, 1, 3, 1);
    run_frame_case("layout");

    // R6 write lands on next frame only
    begin
      logic [15:0] old_l, old_c0;
      old_l = txw_b[0]; old_c0 = txw_b[2];
      wait_frames(1);
      repeat (100) @(posedge clk);
      txw_b[0] = 16'hA5C3; txw_b[2] = 16'h3C5A;
      write_tx(0, txw_b[0]);
      write_tx(2, txw_b[2]);
      wait_frames(1);
      chk(last_frame[0] == old_l, "R6", "left word unchanged in current frame", 32'(last_frame[0]), 32'(old_l));
      chk(last_frame[1] == old_c0, "R6", "control word unchanged in current frame", 32'(last_frame[1]), 32'(old_c0));
      wait_frames(1);
      chk(last_frame[0] == 16'hA5C3, "R6", "left word in next frame", 32'(last_frame[0]), 32'hA5C3);
      chk(last_frame[1] == 16'h3C5A, "R6", "control word in next frame", 32'(last_frame[1]), 32'h3C5A);
    end

    // all on one slot, falling-edge receive, fan-out
    edge_b = 1;
    set_ch(0, 5, 1, 5, 1);
    set_ch(1, 5, 1, 5, 1);
    set_ch(2, 5, 1, 5, 1);
    set_ch(3, 5, 1, 5, 1);
    run_frame_case("collide_all");

    // all disabled
    edge_b = 0;
    set_ch(0, 1, 0, 1, 0);
    set_ch(1, 2, 0, 2, 0);
    set_ch(2, 3, 0, 3, 0);
    set_ch(3, 4, 0, 4, 0);
    run_frame_case("disabled");

    // out-of-range slot numbers
    set_ch(0, 8, 1, 9, 1);
    set_ch(1, 15, 1, 12, 1);
    set_ch(2, 12, 1, 12, 1);
    set_ch(3, 9, 1, 9, 1);
    run_frame_case("high_slots");

    // right beats controls, left disabled on same slot
    edge_b = 1;
    set_ch(0, 6, 0, 7, 1);
    set_ch(1, 6, 1, 0, 1);
    set_ch(2, 6, 1, 6, 1);
    set_ch(3, 6, 1, 6, 1);
    run_frame_case("right_wins");

    // random layouts
    for (int i = 0; i < 10; i++) begin
      edge_b = 1'($urandom);
      for (int c = 0; c < 4; c++)
        set_ch(c, int'($urandom % 12), 1'($urandom), int'($urandom % 12), 1'($urandom));
      run_frame_case("random");
    end

    // overrun and read order
    edge_b = 0;
    set_ch(0, 1, 0, 1, 1);
    set_ch(1, 2, 0, 3, 1);
    set_ch(2, 5, 1, 5, 1);
    set_ch(3, 7, 0, 7, 0);
    for (int s = 0; s < 8; s++) rxpat[s] = 16'($urandom);
    apply_cfg();
    @(posedge clk); #1;
    rx_ready = 1'b0;
    wait_frames(3);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(rx_valid && rx_chan == 2'd0, "R8", "lowest pending channel first", 32'({rx_valid, rx_chan}), 32'h4);
    chk(rx_overrun == 4'b0111, "R9", "overrun on unread channels", 32'(rx_overrun), 32'h7);
    n_ord = 0;
    @(posedge clk); #1;
    rx_ready = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(n_ord == 3 && ord[0] == 0 && ord[1] == 1 && ord[2] == 2, "R8", "drain order",
        32'({ord[0][3:0], ord[1][3:0], ord[2][3:0]}), 32'h012);
    chk(got[0] == rxpat[1], "R7", "left word after overrun", 32'(got[0]), 32'(rxpat[1]));
    chk(rx_valid == 1'b0, "R8", "empty after drain", 32'(rx_valid), 32'h0);
    chk(rx_overrun == 4'b0111, "R9", "overrun stays set", 32'(rx_overrun), 32'h7);

    chk(fs_err == 0 && frames > 20, "R2", "fsync only on bit 127", 32'(fs_err), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule